// File: doc/BRIEF.md
# Three-Phase Output Protection Stage

This block sits between the gate-drive waveform logic of a three-phase motor controller and its six output pads: the positive-side pins for phases U, V and W and their three complementary negative-side pins. Each raw drive request is turned into a pad level. The active polarity is chosen separately for the positive group and the negative group. Any single pin can instead be pinned to a fixed high or low level.

Two protections act on each phase. Shoot-through protection looks at the case where both pins of one phase request the active state in the same cycle. Depending on a mode bit, the stage either forces both pins inactive or lets the request through. In both modes it raises a sticky overlap flag, which software clears with a write-one-to-clear strobe.

An active-low emergency input passes through a synchronizer. When the controller function enable and the output enable are both set, a low level on it latches a cutoff that removes output enable from all six pads. The latch holds until software issues a clear while the synchronized emergency input is high.

Top module: `phase_pad_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pad_out is all zero, overlap_flag is 0 and cutoff_latched is 0.
- R2: pad_out is registered: the value after a rising edge depends only on the inputs sampled at that edge. Bit i (i = 0,1,2 for U,V,W) is the positive pin of phase i, and bit i+3 is its negative pin.
- R3: A pin that is not held and is requested active (drive bit 1) shows pos_act_hi for bits 0..2 or neg_act_hi for bits 3..5. A pin that is not requested shows the inverse of that value.
- R4: When hold_en[j] is 1, pad_out[j] equals hold_lvl[j], whatever the drive requests, polarity or guard mode.
- R5: With guard_block = 1, a phase whose positive and negative requests are both 1 drives both of its non-held pins to their inactive level.
- R6: With guard_block = 0, a phase whose requests are both 1 drives both non-held pins to their active level.
- R7: overlap_flag becomes 1 after any edge at which some phase has both requests at 1, in either guard mode. It then stays 1 until an edge where flag_clr is 1 and no phase overlaps. A new overlap wins over the clear.
- R8: When func_en and out_en are both 1 and estop_n has been low for two edges, cutoff_latched is 1 after the next edge. An estop_n sampled low at edge k sets cutoff_latched after edge k+2. While cutoff_latched is 1, pad_oe is all zero.
- R9: With func_en or out_en at 0, a low estop_n never sets cutoff_latched.
- R10: cutoff_latched clears only at an edge with cutoff_clr = 1 while the synchronized emergency input is high. A clear while it is low has no effect.
- R11: While cutoff_latched is 0, every bit of pad_oe follows out_en with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_pos | input | 3 | Raw active requests for positive pins U,V,W |
| drv_neg | input | 3 | Raw active requests for negative pins U,V,W |
| pos_act_hi | input | 1 | Active level of positive pins (1 = high) |
| neg_act_hi | input | 1 | Active level of negative pins (1 = high) |
| hold_en | input | 6 | Per-pin fixed-level enable |
| hold_lvl | input | 6 | Per-pin fixed level |
| guard_block | input | 1 | 1 = block overlapping phases, 0 = detect only |
| func_en | input | 1 | Motor-control function enable |
| out_en | input | 1 | Motor-control output enable |
| estop_n | input | 1 | Asynchronous active-low emergency cutoff |
| cutoff_clr | input | 1 | Strobe releasing a latched cutoff |
| flag_clr | input | 1 | Write-one-to-clear strobe for overlap_flag |
| pad_out | output | 6 | Pad levels, positive pins in bits 2..0, negative pins in bits 5..3 |
| pad_oe | output | 6 | Pad output enables |
| overlap_flag | output | 1 | Sticky concurrent-active flag |
| cutoff_latched | output | 1 | Emergency cutoff in force |

## Verification
The bench targets cycles where an overlap and a flag clear land together. A design that gave the clear priority would drop that event. It also pulses the emergency input while one of the two enables is off, where a design that armed on only one bit would cut the pads. Clears are issued while the synchronized emergency input is still low, to catch a latch that releases early. Held pins are checked under overlap in block mode, where a design that ran the guard after the hold would force a held pin inactive.

// File: rtl/phase_pad_guard.sv
module phase_pad_guard #(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = 2 * PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] drv_pos,
  input  logic [PHASES-1:0] drv_neg,
  input  logic              pos_act_hi,
  input  logic              neg_act_hi,
  input  logic [PINS-1:0]   hold_en,
  input  logic [PINS-1:0]   hold_lvl,
  input  logic              guard_block,
  input  logic              func_en,
  input  logic              out_en,
  input  logic              estop_n,
  input  logic              cutoff_clr,
  input  logic              flag_clr,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              overlap_flag,
  output logic              cutoff_latched
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   estop_s;
  logic [PHASES-1:0]      both;
  logic [PINS-1:0]        pad_d;
  logic                   armed;

  assign estop_s = sync_q[SYNC_STAGES-1];
  assign armed   = func_en & out_en;
  assign both    = drv_pos & drv_neg;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= estop_n;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], estop_n};
    end
  endgenerate

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    logic kill, ep, en;
    assign kill = guard_block & both[i];
    assign ep   = drv_pos[i] & ~kill;
    assign en   = drv_neg[i] & ~kill;
    assign pad_d[i]        = hold_en[i]        ? hold_lvl[i]
                                               : (ep ? pos_act_hi : ~pos_act_hi);
    assign pad_d[i+PHASES] = hold_en[i+PHASES] ? hold_lvl[i+PHASES]
                                               : (en ? neg_act_hi : ~neg_act_hi);

    // R5
    block_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(guard_block) && $past(both[i]) && !$past(hold_en[i]))
      |-> (pad_out[i] == ~$past(pos_act_hi)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out        <= '0;
      overlap_flag   <= 1'b0;
      cutoff_latched <= 1'b0;
    end else begin
      pad_out      <= pad_d;
      overlap_flag <= (overlap_flag & ~flag_clr) | (|both);
      if (armed && !estop_s)          cutoff_latched <= 1'b1;
      else if (cutoff_clr && estop_s) cutoff_latched <= 1'b0;
    end
  end

  assign pad_oe = {PINS{out_en & ~cutoff_latched}};

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap_flag && !flag_clr) |=> overlap_flag);

  // R8
  cut_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff_latched |-> (pad_oe == '0));

  // R9
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cutoff_latched && !(func_en && out_en)) |=> !cutoff_latched);

  // R10
  cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cutoff_latched && !cutoff_clr) |=> cutoff_latched);

endmodule

// File: tb/tb_phase_pad_guard.sv
module tb_phase_pad_guard;
  logic clk = 0, rst_n = 0;
  logic [2:0] drv_pos = 0, drv_neg = 0;
  logic pos_act_hi = 1, neg_act_hi = 1;
  logic [5:0] hold_en = 0, hold_lvl = 0;
  logic guard_block = 1, func_en = 1, out_en = 1, estop_n = 1;
  logic cutoff_clr = 0, flag_clr = 0;
  logic [5:0] pad_out, pad_oe;
  logic overlap_flag, cutoff_latched;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_pad[6];
  int m_flag = 0, m_cut = 0, m_s1 = 1, m_s2 = 1;
  string m_tag[6];

  always #10 clk = ~clk;

  phase_pad_guard dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int p = 0; p < 3; p++) begin
        int ov, ap, an;
        ov = drv_pos[p] && drv_neg[p];
        ap = drv_pos[p] && !(guard_block && ov);
        an = drv_neg[p] && !(guard_block && ov);
        if (hold_en[p]) begin m_pad[p] = hold_lvl[p]; m_tag[p] = "R4"; end
        else begin
          m_pad[p] = ap ? pos_act_hi : !pos_act_hi;
          m_tag[p] = !ov ? "R2/R3" : (guard_block ? "R5" : "R6");
        end
        if (hold_en[p+3]) begin m_pad[p+3] = hold_lvl[p+3]; m_tag[p+3] = "R4"; end
        else begin
          m_pad[p+3] = an ? neg_act_hi : !neg_act_hi;
          m_tag[p+3] = !ov ? "R2/R3" : (guard_block ? "R5" : "R6");
        end
      end
      m_flag = (m_flag && !flag_clr) || ((drv_pos & drv_neg) != 0);
      if (func_en && out_en && !m_s2) m_cut = 1;
      else if (cutoff_clr && m_s2) m_cut = 0;
      m_s2 = m_s1;
      m_s1 = estop_n;
    end
  end

  task automatic compare_all();
    for (int j = 0; j < 6; j++) chk(m_tag[j], pad_out[j], m_pad[j]);
    chk("R7", overlap_flag, m_flag);
    chk("R8/R9/R10", cutoff_latched, m_cut);
    chk(m_cut ? "R8" : "R11", pad_oe, (out_en && !m_cut) ? 63 : 0);
  endtask

  initial begin
    for (int j = 0; j < 6; j++) begin m_pad[j] = 0; m_tag[j] = "R2"; end
    repeat (3) @(negedge clk);
    chk("R1", pad_out, 0); chk("R1", overlap_flag, 0); chk("R1", cutoff_latched, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pad_out, 0); chk("R1", overlap_flag, 0); chk("R1", cutoff_latched, 0);
    for (int k = 0; k < 6000; k++) begin
      if (k % 64 == 0) begin
        int seg;
        seg = (k / 64) % 8;
        guard_block = seg[0];
        pos_act_hi  = $urandom_range(0, 1);
        neg_act_hi  = $urandom_range(0, 1);
        hold_en     = (seg == 3 || seg == 6) ? 6'($urandom) : 6'd0;
        hold_lvl    = 6'($urandom);
        func_en     = (seg != 2);
        out_en      = (seg != 5);
      end
      drv_pos = 3'($urandom);
      drv_neg = 3'($urandom_range(0, 3) == 0 ? $urandom : 0);
      if (k % 64 == 20) estop_n = 0;
      if (k % 64 == 28) estop_n = 1;
      cutoff_clr = ($urandom_range(0, 7) == 0);
      flag_clr   = ($urandom_range(0, 5) == 0);
      if ((k % 200) == 150) out_en = !out_en;
      @(negedge clk);
      compare_all();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule